// File: doc/BRIEF.md
# Odd-Parity SECDED Codec for a Data Nibble

This combinational block guards a 4-bit data word with an extended Hamming code that corrects any single bit error and detects any double error. It has two independent paths. The encoder path turns a data nibble into an 8-bit codeword. The decoder path takes a received codeword that may have been damaged, returns the repaired data nibble, and reports exactly one of four outcomes: clean, data bit repaired, check bit hit, or uncorrectable.

All check bits follow odd parity. Every check group, counting its own check bit, holds an odd number of ones, and so does the whole codeword. For this reason an all-zero codeword is not valid. The encoder first places the data bits into the codeword and then fills in each check bit in place. The decoder builds a syndrome that is zero for a group with odd parity. It then sorts the syndrome and the overall-parity result into classes and flips at most one data bit.

Top module: `hsc_codec`

## Requirements
- R1: Codeword layout on `code_out`: data bits d0, d1, d2 and d3 sit at bits 2, 4, 5 and 6. Check bits sit at bits 0, 1 and 3. The overall parity bit sits at bit 7. Bit i (0 to 6) is Hamming position i+1.
- R2: For each k in 0..2, the XOR of all `code_out` bits i (0 to 6) whose position i+1 has bit k set equals 1 (odd parity).
- R3: The XOR of all eight `code_out` bits equals 1.
- R4: A valid codeword on `code_in` raises only `flag_clean`, and `dout` equals the data bits of `code_in` at bits 2, 4, 5 and 6.
- R5: A valid codeword with one of bits 2, 4, 5 or 6 inverted raises only `flag_data_fix`, and `dout` returns the original data.
- R6: A valid codeword with one of bits 0, 1, 3 or 7 inverted raises only `flag_chk_fix`, and `dout` equals the unchanged data.
- R7: A valid codeword with any two bits inverted raises only `flag_uncorr`, and `dout` equals the received data bits with no bit flipped.
- R8: For every value of `code_in`, exactly one of the four flags is 1.
- R9: The encoder and the decoder work at the same time without affecting each other. `code_out` depends only on `din`, and the decoder outputs depend only on `code_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 4 | Data nibble to encode |
| code_out | output | 8 | Encoded odd-parity codeword |
| code_in | input | 8 | Received codeword to decode |
| dout | output | 4 | Corrected data nibble |
| flag_clean | output | 1 | No error found |
| flag_data_fix | output | 1 | One data bit was repaired |
| flag_chk_fix | output | 1 | One check or overall parity bit was wrong; data passed through |
| flag_uncorr | output | 1 | Double error or unused syndrome; data passed through |

## Verification
Encoding and decoding can happen in the same cycle, because both paths are live at once. The bench always presents a `din` that differs from the data carried in `code_in`, so any leakage between the paths shows up as a wrong codeword or a wrong repair. In every cycle the bench compares `code_out` with its own encoder model and its own odd-parity group scan. In the same cycle it compares the flags and `dout` with the outcome expected from the bits it flipped. It covers all 16 data values with no flip, with each of the 8 single flips, and with each of the 28 pairs of flips.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [2:0] {
    CLS_CLEAN  = 3'd0,
    CLS_DATA   = 3'd1,
    CLS_CHECK  = 3'd2,
    CLS_DOUBLE = 3'd3,
    CLS_UNUSED = 3'd4
  } cls_e;

  function automatic int chk_count(int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int data_pos(int j);
    int cnt;
    int pos;
    cnt = -1;
    pos = 0;
    for (int q = 1; q < 64; q++) begin
      if (!is_pow2(q) && pos == 0) begin
        cnt++;
        if (cnt == j) pos = q;
      end
    end
    return pos;
  endfunction

  function automatic bit in_group(int pos, int k);
    return ((pos >> k) & 1) == 1;
  endfunction

endpackage

// File: rtl/hsc_encoder.sv
module hsc_encoder #(
  parameter int DATA_W = 4,
  parameter int P_W    = 3,
  parameter int CW_W   = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [CW_W-1:0]   code
);
  localparam int HAM_N = CW_W - 1;

  always_comb begin
    logic acc;
    code = '0;
    for (int j = 0; j < DATA_W; j++) begin
      code[hsc_pkg::data_pos(j) - 1] = din[j];
    end
    for (int k = 0; k < P_W; k++) begin
      acc = 1'b1;
      for (int i = 0; i < HAM_N; i++) begin
        if (hsc_pkg::in_group(i + 1, k)) acc = acc ^ code[i];
      end
      code[(1 << k) - 1] = acc;
    end
    code[CW_W-1] = ~(^code[HAM_N-1:0]);
  end

endmodule

// File: rtl/hsc_syndrome.sv
module hsc_syndrome #(
  parameter int P_W  = 3,
  parameter int CW_W = 8
) (
  input  logic [CW_W-1:0] code,
  output logic [P_W-1:0]  synd,
  output logic            ovr_mis
);
  localparam int HAM_N = CW_W - 1;

  always_comb begin
    logic acc;
    for (int k = 0; k < P_W; k++) begin
      acc = 1'b1;
      for (int i = 0; i < HAM_N; i++) begin
        if (hsc_pkg::in_group(i + 1, k)) acc = acc ^ code[i];
      end
      synd[k] = acc;
    end
    ovr_mis = ~(^code);
  end

endmodule

// File: rtl/hsc_classify.sv
module hsc_classify #(
  parameter int DATA_W = 4,
  parameter int P_W    = 3,
  parameter int CW_W   = 8
) (
  input  logic [P_W-1:0]    synd,
  input  logic              ovr_mis,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] dout,
  output hsc_pkg::cls_e     cls
);
  localparam int HAM_N = CW_W - 1;

  logic [DATA_W-1:0] flip_mask;
  int                spos;

  always_comb begin
    spos      = int'(synd);
    flip_mask = '0;
    if (spos == 0) begin
      cls = ovr_mis ? hsc_pkg::CLS_CHECK : hsc_pkg::CLS_CLEAN;
    end else if (!ovr_mis) begin
      cls = hsc_pkg::CLS_DOUBLE;
    end else if (spos > HAM_N) begin
      cls = hsc_pkg::CLS_UNUSED;
    end else if (hsc_pkg::is_pow2(spos)) begin
      cls = hsc_pkg::CLS_CHECK;
    end else begin
      cls = hsc_pkg::CLS_DATA;
      for (int j = 0; j < DATA_W; j++) begin
        if (hsc_pkg::data_pos(j) == spos) flip_mask[j] = 1'b1;
      end
    end
    dout = rx_data ^ flip_mask;
  end

  always_comb begin
    if (cls == hsc_pkg::CLS_CLEAN)
      AST_CLEAN_PASS: assert (dout == rx_data) else $error("clean altered data"); // R4
    if (cls == hsc_pkg::CLS_DATA)
      AST_DATA_FIX_ONE: assert ($countones(dout ^ rx_data) == 1) else $error("repair not one bit"); // R5
    if (cls == hsc_pkg::CLS_CHECK)
      AST_CHK_PASS: assert (dout == rx_data) else $error("check error altered data"); // R6
    if (cls == hsc_pkg::CLS_DOUBLE || cls == hsc_pkg::CLS_UNUSED)
      AST_UNCORR_PASS: assert (dout == rx_data) else $error("false correction"); // R7
  end

endmodule

// File: rtl/hsc_codec.sv
module hsc_codec #(
  parameter  int DATA_W = 4,
  localparam int P_W    = hsc_pkg::chk_count(DATA_W),
  localparam int CW_W   = DATA_W + P_W + 1
) (
  input  logic [DATA_W-1:0] din,
  output logic [CW_W-1:0]   code_out,
  input  logic [CW_W-1:0]   code_in,
  output logic [DATA_W-1:0] dout,
  output logic              flag_clean,
  output logic              flag_data_fix,
  output logic              flag_chk_fix,
  output logic              flag_uncorr
);

  logic [P_W-1:0]    synd;
  logic              ovr_mis;
  logic [DATA_W-1:0] rx_data;
  hsc_pkg::cls_e     cls;

  hsc_encoder #(.DATA_W(DATA_W), .P_W(P_W), .CW_W(CW_W)) u_enc (
    .din  (din),
    .code (code_out)
  );

  hsc_syndrome #(.P_W(P_W), .CW_W(CW_W)) u_syn (
    .code    (code_in),
    .synd    (synd),
    .ovr_mis (ovr_mis)
  );

  for (genvar j = 0; j < DATA_W; j++) begin : g_rx
    assign rx_data[j] = code_in[hsc_pkg::data_pos(j) - 1];
  end

  hsc_classify #(.DATA_W(DATA_W), .P_W(P_W), .CW_W(CW_W)) u_cls (
    .synd    (synd),
    .ovr_mis (ovr_mis),
    .rx_data (rx_data),
    .dout    (dout),
    .cls     (cls)
  );

  assign flag_clean    = (cls == hsc_pkg::CLS_CLEAN);
  assign flag_data_fix = (cls == hsc_pkg::CLS_DATA);
  assign flag_chk_fix  = (cls == hsc_pkg::CLS_CHECK);
  assign flag_uncorr   = (cls == hsc_pkg::CLS_DOUBLE) || (cls == hsc_pkg::CLS_UNUSED);

  always_comb begin
    AST_ONE_CLASS: assert ($countones({flag_clean, flag_data_fix, flag_chk_fix, flag_uncorr}) == 1)
      else $error("flags not one-hot"); // R8
    if (synd == '0 && !ovr_mis)
      AST_CLEAN_ON_ZERO: assert (flag_clean && dout == rx_data) else $error("zero syndrome not clean"); // R4
    if (synd != '0 && !ovr_mis)
      AST_DOUBLE_FLAGGED: assert (flag_uncorr) else $error("double error missed"); // R7
  end

endmodule

// File: tb/hsc_codec_tb.sv
module hsc_codec_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] din = '0;
  logic [7:0] code_in = '0;
  logic [7:0] code_out;
  logic [3:0] dout;
  logic       flag_clean, flag_data_fix, flag_chk_fix, flag_uncorr;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  hsc_codec u_dut (
    .din           (din),
    .code_out      (code_out),
    .code_in       (code_in),
    .dout          (dout),
    .flag_clean    (flag_clean),
    .flag_data_fix (flag_data_fix),
    .flag_chk_fix  (flag_chk_fix),
    .flag_uncorr   (flag_uncorr)
  );

  // Reference encoder written from R1..R3
  function automatic logic [7:0] ref_enc(logic [3:0] d);
    logic [7:0] w;
    w = '0;
    w[2] = d[0]; w[4] = d[1]; w[5] = d[2]; w[6] = d[3];
    w[0] = ~(d[0] ^ d[1] ^ d[3]);
    w[1] = ~(d[0] ^ d[2] ^ d[3]);
    w[3] = ~(d[1] ^ d[2] ^ d[3]);
    w[7] = ~(^w[6:0]);
    return w;
  endfunction

  function automatic logic [3:0] data_of(logic [7:0] w);
    return {w[6], w[5], w[4], w[2]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Compare the encoder against the model and scan parity groups (R1, R2, R3, R9)
  task automatic check_enc(logic [3:0] d);
    logic [7:0] e;
    int par;
    e = ref_enc(d);
    check("R1 layout", int'(code_out), int'(e));
    check("R9 encoder isolated", int'(code_out), int'(e));
    for (int k = 0; k < 3; k++) begin
      par = 0;
      for (int i = 0; i < 7; i++) if (((i + 1) >> k) & 1) par ^= int'(code_out[i]);
      check("R2 group odd", par, 1);
    end
    check("R3 overall odd", int'(^code_out), 1);
  endtask

  task automatic apply(logic [3:0] d_enc, logic [7:0] rx, int exp_cls, logic [3:0] exp_d, string req);
    @(posedge clk);
    #1;
    din     = d_enc;
    code_in = rx;
    @(negedge clk);
    check_enc(d_enc);
    check({req, " clean"},    int'(flag_clean),    int'(exp_cls == 0));
    check({req, " data_fix"}, int'(flag_data_fix), int'(exp_cls == 1));
    check({req, " chk_fix"},  int'(flag_chk_fix),  int'(exp_cls == 2));
    check({req, " uncorr"},   int'(flag_uncorr),   int'(exp_cls == 3));
    check({req, " dout"},     int'(dout),          int'(exp_d));
    check("R8 one flag", flag_clean + flag_data_fix + flag_chk_fix + flag_uncorr, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] cw;
    logic [7:0] rx;
    bit         is_data;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset-time inputs of zero give the all-zero-data codeword
    check("R1 reset codeword", int'(code_out), 8'h0B);

    for (int d = 0; d < 16; d++) begin
      cw = ref_enc(4'(d));
      // R4 with a different nibble on the encoder (R9)
      apply(4'(d ^ 5), cw, 0, 4'(d), "R4");
      for (int b = 0; b < 8; b++) begin
        rx = cw ^ (8'd1 << b);
        is_data = (b == 2) || (b == 4) || (b == 5) || (b == 6);
        if (is_data) apply(4'(d + 3), rx, 1, 4'(d), "R5");
        else         apply(4'(d + 3), rx, 2, 4'(d), "R6");
      end
      for (int a = 0; a < 8; a++) begin
        for (int b = a + 1; b < 8; b++) begin
          rx = cw ^ (8'd1 << a) ^ (8'd1 << b);
          apply(4'(15 - d), rx, 3, data_of(rx), "R7");
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule